// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block conditions a bank of external interrupt lines before they reach a parent interrupt controller. Each line is synchronised, sensed as a level or as an edge of a chosen polarity, latched as a request, and forwarded on its own output bit when the line is unmasked. Software handles the unit through a small single-cycle register port. That port holds the enable, polarity and trigger-type words, a write-one-to-clear request word and a read-only pending word.

Level requests and edge requests are both latched, but they follow different clear rules. A level request cannot be cleared while its input is still active, so a handler that clears too early leaves the request set. An edge request is meant to be cleared before the handler runs. An edge that arrives after that clear, or in the same cycle as it, latches a new request, so no event is lost. After software changes a line's trigger type or polarity, the unit clears that line's request, so a request left over from the old setting does not survive.

The register port has no data stream, so it has no valid/ready handshake. A write takes effect at the clock edge that samples it. A read returns its data on `reg_rdata` one cycle after the read strobe, and `reg_rdata` holds that value until the next read.

Top module: `ext_irq_unit`

## Requirements
- R1: Bit i of the trigger word (address 2) selects the mode of line i: 1 selects edge sensing and 0 selects level sensing.
- R2: Bit i of the polarity word (address 1) selects the active sense of line i: 0 means active-high and 1 means active-low. It applies in both level and edge mode.
- R3: Writing address 3 clears the latched request of each line whose data bit is 1. Data bits that are 0 leave their lines unchanged. Reading address 3 returns 0.
- R4: A level-mode request stays latched after its input becomes inactive, until it is cleared.
- R5: A clear written to a level-mode line whose synchronised input is still active has no effect, in that cycle or later.
- R6: An edge-mode line latches a new request on an active edge that arrives after a clear. If the edge and the clear fall on the same cycle, the request stays set.
- R7: When a write changes line i's trigger or polarity bit, line i's request is cleared in the next cycle, using the new setting. Lines whose bits did not change keep their requests.
- R8: Bit i of the enable word (address 0) set to 1 drives line i's request onto `irq_out[i]`. When the bit is 0, `irq_out[i]` is 0 and the latched request is kept.
- R9: Address 4 reads the latched requests before masking. Writes to address 4 are ignored.
- R10: After reset, the enable, polarity and trigger words are all zero, so every line is masked, level mode and active-high. No request is pending and `irq_out` is zero.
- R11: A change on `irq_in` reaches the latched request on the third rising edge. `reg_rdata` takes its value at the edge that samples `reg_rd` and holds it while there is no read.
- R12: An edge-mode line does not latch a request on an edge in its inactive direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NLINES | Asynchronous external interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NLINES | Register write data |
| reg_rdata | output | NLINES | Register read data, one cycle after the strobe |
| irq_out | output | NLINES | Masked requests to the parent controller |

## Verification
The assertions take for granted that `reg_wr` and `reg_rd` are never high in the same cycle, and that `irq_in` changes only away from the clock edge. Given that, the synchronised value is a clean sample, and the edge and level properties may compare it against the previous cycle. The stimulus changes inputs only after the clock edge, and the bench issues reads and writes one at a time through separate tasks. Input pulses are held for several cycles, so every edge passes cleanly through the synchroniser.

// File: rtl/eiu_pkg.sv
package eiu_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_POL     = 3'd1;
  localparam logic [ADDR_W-1:0] A_TRIG    = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLEAR   = 3'd3;
  localparam logic [ADDR_W-1:0] A_PENDING = 3'd4;
endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eiu_line.sv
module eiu_line (
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  input  logic low_active,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic s_prev;
  logic hit_level;
  logic hit_edge;
  logic hit;

  always_comb begin
    hit_level = !edge_mode && (s ^ low_active);
    hit_edge  = edge_mode && (low_active ? (!s && s_prev) : (s && !s_prev));
    hit       = hit_level || hit_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_prev <= 1'b0;
      req    <= 1'b0;
    end else begin
      s_prev <= s;
      if (hit)      req <= 1'b1;
      else if (clr) req <= 1'b0;
    end
  end
endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
  import eiu_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      pending,
  output logic [N-1:0]      en,
  output logic [N-1:0]      pol,
  output logic [N-1:0]      trig,
  output logic [N-1:0]      clr,
  output logic [N-1:0]      rdata
);
  logic [N-1:0] chg_q;
  logic [N-1:0] sw_clr;
  logic [N-1:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= '0;
      pol   <= '0;
      trig  <= '0;
      chg_q <= '0;
    end else begin
      chg_q <= '0;
      if (wr) begin
        unique case (addr)
          A_ENABLE: en <= wdata;
          A_POL: begin
            pol   <= wdata;
            chg_q <= wdata ^ pol;
          end
          A_TRIG: begin
            trig  <= wdata;
            chg_q <= wdata ^ trig;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    sw_clr = (wr && addr == A_CLEAR) ? wdata : '0;
    clr    = sw_clr | chg_q;
  end

  always_comb begin
    unique case (addr)
      A_ENABLE:  rd_mux = en;
      A_POL:     rd_mux = pol;
      A_TRIG:    rd_mux = trig;
      A_PENDING: rd_mux = pending;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import eiu_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NLINES-1:0] reg_wdata,
  output logic [NLINES-1:0] reg_rdata,
  output logic [NLINES-1:0] irq_out
);
  logic [NLINES-1:0] s_sync;
  logic [NLINES-1:0] en_w;
  logic [NLINES-1:0] pol_w;
  logic [NLINES-1:0] trig_w;
  logic [NLINES-1:0] clr_w;
  logic [NLINES-1:0] req_w;

  eiu_sync #(.W(NLINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(s_sync)
  );

  eiu_regs #(.N(NLINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .pending(req_w), .en(en_w), .pol(pol_w),
    .trig(trig_w), .clr(clr_w), .rdata(reg_rdata)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    eiu_line u_line (
      .clk(clk), .rst_n(rst_n), .s(s_sync[i]), .low_active(pol_w[i]),
      .edge_mode(trig_w[i]), .clr(clr_w[i]), .req(req_w[i])
    );
  end

  assign irq_out = req_w & en_w;
endmodule

// File: rtl/eiu_checker.sv
module eiu_checker #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd,
  input logic [N-1:0] rdata,
  input logic [N-1:0] s,
  input logic [N-1:0] pol,
  input logic [N-1:0] trig,
  input logic [N-1:0] clr,
  input logic [N-1:0] req
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(req) & ~$past(clr)) & ~req) == '0));

  assert_level_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((~$past(trig) & ($past(s) ^ $past(pol))) & ~req) == '0));

  assert_edge_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(trig) &
      ((~$past(pol) & $past(s) & ~$past(s, 2)) |
       ($past(pol) & ~$past(s) & $past(s, 2)))) & ~req) == '0));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

bind ext_irq_unit eiu_checker #(.N(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(reg_rd), .rdata(reg_rdata), .s(s_sync),
  .pol(pol_w), .trig(trig_w), .clr(clr_w), .req(req_w)
);

// File: tb/sim_ext_irq_unit.sv
module sim_ext_irq_unit;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic         reg_wr = 1'b0;
  logic         reg_rd = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic [N-1:0] irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  ext_irq_unit #(.NLINES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    reg_rd = 1'b1; reg_addr = a;
    tick(1);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R10: reset state
    rd(3'd0, v); chk("R10 enable", v, '0);
    rd(3'd1, v); chk("R10 polarity", v, '0);
    rd(3'd2, v); chk("R10 trigger", v, '0);
    rd(3'd4, v); chk("R10 pending", v, '0);
    chk("R10 irq_out", irq_out, '0);

    // Sweep of line x mode x polarity
    for (int l = 0; l < N; l++) begin
      for (int t = 0; t < 2; t++) begin
        for (int p = 0; p < 2; p++) begin
          logic [N-1:0] b;
          logic [N-1:0] idle;
          b = '0; b[l] = 1'b1;
          idle = p ? b : '0;
          wr(3'd0, '0);
          irq_in = idle;
          wr(3'd2, t ? b : '0);
          wr(3'd1, p ? b : '0);
          tick(5);
          wr(3'd3, ALL);
          wr(3'd0, ALL);
          rd(3'd1, v); chk("R2 polarity readback", v, p ? b : '0);
          rd(3'd2, v); chk("R1 trigger readback", v, t ? b : '0);
          rd(3'd4, v); chk("R3 clear to idle", v, '0);
          irq_in = idle ^ b;                 // active level / active edge
          tick(3);
          rd(3'd4, v); chk("R1 R2 R11 request latched", v, b);
          chk("R8 irq_out forwards", irq_out, b);
          irq_in = idle;                     // back to inactive
          tick(4);
          rd(3'd4, v); chk("R4 request held", v, b);
          wr(3'd3, '0);
          rd(3'd4, v); chk("R3 zero clear no effect", v, b);
          wr(3'd0, '0);
          chk("R8 masked output", irq_out, '0);
          rd(3'd4, v); chk("R8 masked keeps pending", v, b);
          wr(3'd0, ALL);
          if (t == 0) begin
            irq_in = idle ^ b;
            tick(4);
            wr(3'd3, b);
            rd(3'd4, v); chk("R5 clear overridden", v, b);
            irq_in = idle;
            tick(4);
            wr(3'd3, b);
            rd(3'd4, v); chk("R3 level cleared", v, '0);
          end else begin
            wr(3'd3, b);
            rd(3'd4, v); chk("R6 edge cleared", v, '0);
            irq_in = idle ^ b;
            tick(4);
            rd(3'd4, v); chk("R6 fresh edge latched", v, b);
            wr(3'd3, b);
            irq_in = idle;
            tick(4);
            rd(3'd4, v); chk("R12 inactive edge ignored", v, '0);
            irq_in = idle ^ b;
            tick(2);
            wr(3'd3, b);                     // sampled at the edge that latches
            rd(3'd4, v); chk("R6 edge beats clear", v, b);
            irq_in = idle;
            tick(4);
            wr(3'd3, b);
          end
        end
      end
    end

    // R7: config change clears stale request, other lines kept
    wr(3'd1, '0); wr(3'd2, 4'b0010); irq_in = '0;
    tick(4); wr(3'd3, ALL);
    irq_in = 4'b0011;
    tick(4);
    rd(3'd4, v); chk("R7 setup", v, 4'b0011);
    wr(3'd1, 4'b0001);  // line 0 becomes active-low; input high is inactive
    tick(1);
    rd(3'd4, v); chk("R7 polarity change clears only line 0", v, 4'b0010);
    irq_in = 4'b0010;   // line 0 low: active under new polarity
    tick(4);
    rd(3'd4, v); chk("R7 new setting latches", v, 4'b0011);
    wr(3'd2, 4'b0011);  // line 0 to edge: stale level request cleared
    tick(1);
    rd(3'd4, v); chk("R7 trigger change clears", v, 4'b0010);

    // R9: pending is read-only; R3: clear register reads zero
    wr(3'd4, '0);
    rd(3'd4, v); chk("R9 pending write ignored", v, 4'b0010);
    rd(3'd3, v); chk("R3 clear reads zero", v, '0);
    // R11: rdata holds without a read
    tick(3);
    chk("R11 rdata held", reg_rdata, '0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule